// File: doc/BRIEF.md
# Two-Source Interrupt Acceptance Unit

This block sits beside a CPU core's sequencer and decides whether, and which, interrupt is taken. Two requesters feed it. The first is a 4-bit external priority level that is sampled every cycle and stays pending for as long as the input holds it. The second is an on-chip peripheral that raises a one-cycle strobe together with a level and a 7-bit vector. That request stays latched until it is accepted, and acceptance clears it.

Each cycle the block picks a winner. The external level wins only when it is strictly greater than the internal one. The winner's level is then compared with the 4-bit mask field of the status register, bits 7:4. The core signals instruction boundaries and branch delay slots. When an unmasked winner is present at a boundary that is not a delay slot, the block emits a one-cycle take pulse. The pulse carries the vector number and the status word with the mask field replaced by the accepted level, and one acknowledge line names the source taken. The vector for an external level is 64 plus half the level.

The controller is a three-state machine:
- `ST_IDLE` moves to `ST_TAKE` on acceptance.
- `ST_TAKE` moves to `ST_ENTRY`, or back to `ST_IDLE` when the entry length is 1.
- `ST_ENTRY` counts and returns to `ST_IDLE` when the entry time has run out.

Busy is high in `ST_TAKE` and `ST_ENTRY`, and no new acceptance is tested while busy is high.

Top module: `irq_accept_unit`

## Requirements
- R1: The external request is chosen only when its pending level is strictly greater than the internal pending level; on equal levels the internal request is chosen.
- R2: The chosen request is taken only when its level is greater than status bits 7:4; a level of 0 is never taken.
- R3: When the external source is taken, `vector_o` equals 64 + level/2 (integer division).
- R4: When the internal source is taken, `vector_o` equals the 7-bit vector latched with that request.
- R5: With the take pulse, `status_o` carries the accepted level in bits 7:4 and every other bit copied from `status_i` of the deciding cycle. `vector_o` and `status_o` are zero outside the take pulse.
- R6: Acceptance clears the internal pending request. The external level stays pending while its input holds, and is taken again once busy ends if it is still unmasked.
- R7: Acceptance is decided only in a cycle with `boundary_i`=1 and `delay_slot_i`=0. `take_o` is high for exactly the following cycle.
- R8: `busy_o` is high for 13 consecutive cycles, starting with the take cycle. No acceptance is decided while `busy_o` is high.
- R9: During `take_o`, exactly one of `ack_ext_o` and `ack_int_o` is high, naming the taken source. Both are low otherwise.
- R10: `int_req_i` latches `int_level_i` and `int_vector_i` together and replaces any older internal request. A strobe in the accepting cycle keeps the new request pending.
- R11: After reset, all outputs are zero, both pending requests are empty and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_level_i | input | 4 | External priority level, 0 = none |
| int_req_i | input | 1 | Peripheral request strobe |
| int_level_i | input | 4 | Peripheral request level |
| int_vector_i | input | 7 | Peripheral request vector |
| status_i | input | 32 | Current status register, mask in bits 7:4 |
| boundary_i | input | 1 | Core is at an instruction boundary |
| delay_slot_i | input | 1 | Boundary lies in a branch delay slot |
| take_o | output | 1 | One-cycle accept pulse |
| vector_o | output | 7 | Vector number of the taken request |
| status_o | output | 32 | Status word with new mask level |
| ack_ext_o | output | 1 | External source taken |
| ack_int_o | output | 1 | Internal source taken |
| busy_o | output | 1 | Interrupt entry in progress |

## Verification
A corrupted pending register shows up one cycle after the next qualifying boundary. It appears as a wrong vector or status level, a wrong acknowledge, or a take that is missing or extra. A pending internal request that is never cleared shows up as a repeat acceptance right after busy ends. A miscounted entry timer moves the falling edge of `busy_o` and the earliest next take by the same number of cycles. The reference model is compared every cycle, so each of these faults is flagged in the first cycle in which it reaches a port.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKE  = 2'd1,
        ST_ENTRY = 2'd2
    } entry_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_INT  = 2'd2
    } irq_src_e;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int LVL_W = 4,
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ext_level_i,
    input  logic             int_req_i,
    input  logic [LVL_W-1:0] int_level_i,
    input  logic [VEC_W-1:0] int_vector_i,
    input  logic             clr_int_i,
    output logic [LVL_W-1:0] ext_lvl_o,
    output logic [LVL_W-1:0] int_lvl_o,
    output logic [VEC_W-1:0] int_vec_o
);

    logic [LVL_W-1:0] ext_q;
    logic [LVL_W-1:0] int_lvl_q;
    logic [VEC_W-1:0] int_vec_q;

    // External level follows its input; it is pending as long as it is held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else begin
            ext_q <= ext_level_i;
        end
    end

    // Internal request: a new strobe has priority over the clear from acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_lvl_q <= '0;
            int_vec_q <= '0;
        end else if (int_req_i) begin
            int_lvl_q <= int_level_i;
            int_vec_q <= int_vector_i;
        end else if (clr_int_i) begin
            int_lvl_q <= '0;
            int_vec_q <= '0;
        end
    end

    assign ext_lvl_o = ext_q;
    assign int_lvl_o = int_lvl_q;
    assign int_vec_o = int_vec_q;

    // R6
    int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int_i && !int_req_i) |=> (int_lvl_o == '0));

    // R10
    int_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_i |=> (int_lvl_o == $past(int_level_i) && int_vec_o == $past(int_vector_i)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter int LVL_W        = 4,
    parameter int VEC_W        = 7,
    parameter int SR_W         = 32,
    parameter int MASK_LSB     = 4,
    parameter int EXT_VEC_BASE = 64
) (
    input  logic [LVL_W-1:0] ext_lvl_i,
    input  logic [LVL_W-1:0] int_lvl_i,
    input  logic [VEC_W-1:0] int_vec_i,
    input  logic [SR_W-1:0]  status_i,
    output logic             win_valid_o,
    output irq_src_e         win_src_o,
    output logic [LVL_W-1:0] win_level_o,
    output logic [VEC_W-1:0] win_vector_o
);

    localparam logic [VEC_W-1:0] EXT_BASE_V = VEC_W'(EXT_VEC_BASE);

    logic [LVL_W-1:0] cur_mask;
    logic             ext_wins;
    logic [VEC_W-1:0] ext_vector;

    assign cur_mask   = status_i[MASK_LSB +: LVL_W];
    assign ext_wins   = (ext_lvl_i > int_lvl_i);
    assign ext_vector = EXT_BASE_V + VEC_W'(ext_lvl_i >> 1);

    always_comb begin
        if (ext_wins) begin
            win_level_o  = ext_lvl_i;
            win_vector_o = ext_vector;
        end else begin
            win_level_o  = int_lvl_i;
            win_vector_o = int_vec_i;
        end
        win_valid_o = (win_level_o > cur_mask);
        if (!win_valid_o) begin
            win_src_o = SRC_NONE;
        end else if (ext_wins) begin
            win_src_o = SRC_EXT;
        end else begin
            win_src_o = SRC_INT;
        end
    end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_accept_pkg::*;
#(
    parameter int LVL_W        = 4,
    parameter int VEC_W        = 7,
    parameter int SR_W         = 32,
    parameter int MASK_LSB     = 4,
    parameter int ENTRY_CYCLES = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             delay_slot_i,
    input  logic             win_valid_i,
    input  irq_src_e         win_src_i,
    input  logic [LVL_W-1:0] win_level_i,
    input  logic [VEC_W-1:0] win_vector_i,
    input  logic [SR_W-1:0]  status_i,
    output logic             clr_int_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [SR_W-1:0]  status_o,
    output logic             ack_ext_o,
    output logic             ack_int_o,
    output logic             busy_o
);

    localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    entry_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic [SR_W-1:0]  new_status;
    logic [VEC_W-1:0] vector_q;
    logic [SR_W-1:0]  status_q;
    logic             ack_ext_q, ack_int_q;

    assign accept    = (state_q == ST_IDLE) && boundary_i && !delay_slot_i && win_valid_i;
    assign clr_int_o = accept && (win_src_i == SRC_INT);

    always_comb begin
        new_status = status_i;
        new_status[MASK_LSB +: LVL_W] = win_level_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_TAKE;
                end
            end
            ST_TAKE: begin
                state_d = (cnt_q == CNT_LAST) ? ST_IDLE : ST_ENTRY;
            end
            ST_ENTRY: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and entry counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= CNT_ONE;
            end else if (state_q != ST_IDLE && cnt_q != CNT_LAST) begin
                cnt_q <= cnt_q + CNT_ONE;
            end else if (state_q != ST_IDLE) begin
                cnt_q <= '0;
            end
        end
    end

    // Output registers: loaded on acceptance, cleared otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vector_q  <= '0;
            status_q  <= '0;
            ack_ext_q <= 1'b0;
            ack_int_q <= 1'b0;
        end else if (accept) begin
            vector_q  <= win_vector_i;
            status_q  <= new_status;
            ack_ext_q <= (win_src_i == SRC_EXT);
            ack_int_q <= (win_src_i == SRC_INT);
        end else begin
            vector_q  <= '0;
            status_q  <= '0;
            ack_ext_q <= 1'b0;
            ack_int_q <= 1'b0;
        end
    end

    assign take_o    = (state_q == ST_TAKE);
    assign busy_o    = (state_q != ST_IDLE);
    assign vector_o  = vector_q;
    assign status_o  = status_q;
    assign ack_ext_o = ack_ext_q;
    assign ack_int_o = ack_int_q;

    // Length of the most recent busy run, counted for the checks below
    logic [CNT_W:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= take_o ? (CNT_W+1)'(1) : busy_run + (CNT_W+1)'(1);
        end
    end

    // R7
    take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i && !delay_slot_i));

    // R7
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R8
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run == (CNT_W+1)'(ENTRY_CYCLES)));

    // R8
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_run <= (CNT_W+1)'(ENTRY_CYCLES)));

    // R9
    ack_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones({ack_ext_o, ack_int_o}) == 1));

    // R9
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (!ack_ext_o && !ack_int_o));

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int LVL_W        = 4,
    parameter int VEC_W        = 7,
    parameter int SR_W         = 32,
    parameter int MASK_LSB     = 4,
    parameter int EXT_VEC_BASE = 64,
    parameter int ENTRY_CYCLES = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ext_level_i,
    input  logic             int_req_i,
    input  logic [LVL_W-1:0] int_level_i,
    input  logic [VEC_W-1:0] int_vector_i,
    input  logic [SR_W-1:0]  status_i,
    input  logic             boundary_i,
    input  logic             delay_slot_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [SR_W-1:0]  status_o,
    output logic             ack_ext_o,
    output logic             ack_int_o,
    output logic             busy_o
);

    localparam logic [SR_W-1:0] MASK_BITS = {{(SR_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << MASK_LSB;

    logic [LVL_W-1:0] ext_lvl, int_lvl, win_level;
    logic [VEC_W-1:0] int_vec, win_vector;
    logic             win_valid, clr_int;
    irq_src_e         win_src;

    irq_pending #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_pending (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_level_i  (ext_level_i),
        .int_req_i    (int_req_i),
        .int_level_i  (int_level_i),
        .int_vector_i (int_vector_i),
        .clr_int_i    (clr_int),
        .ext_lvl_o    (ext_lvl),
        .int_lvl_o    (int_lvl),
        .int_vec_o    (int_vec)
    );

    irq_arbiter #(
        .LVL_W(LVL_W), .VEC_W(VEC_W), .SR_W(SR_W),
        .MASK_LSB(MASK_LSB), .EXT_VEC_BASE(EXT_VEC_BASE)
    ) u_arbiter (
        .ext_lvl_i    (ext_lvl),
        .int_lvl_i    (int_lvl),
        .int_vec_i    (int_vec),
        .status_i     (status_i),
        .win_valid_o  (win_valid),
        .win_src_o    (win_src),
        .win_level_o  (win_level),
        .win_vector_o (win_vector)
    );

    irq_entry_fsm #(
        .LVL_W(LVL_W), .VEC_W(VEC_W), .SR_W(SR_W),
        .MASK_LSB(MASK_LSB), .ENTRY_CYCLES(ENTRY_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary_i   (boundary_i),
        .delay_slot_i (delay_slot_i),
        .win_valid_i  (win_valid),
        .win_src_i    (win_src),
        .win_level_i  (win_level),
        .win_vector_i (win_vector),
        .status_i     (status_i),
        .clr_int_o    (clr_int),
        .take_o       (take_o),
        .vector_o     (vector_o),
        .status_o     (status_o),
        .ack_ext_o    (ack_ext_o),
        .ack_int_o    (ack_int_o),
        .busy_o       (busy_o)
    );

    // R2
    mask_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (status_o[MASK_LSB +: LVL_W] > $past(status_i[MASK_LSB +: LVL_W])));

    // R5
    other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((status_o & ~MASK_BITS) == ($past(status_i) & ~MASK_BITS)));

    // R3
    ext_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_ext_o) |->
            (vector_o == VEC_W'(EXT_VEC_BASE) + VEC_W'(status_o[MASK_LSB +: LVL_W] >> 1)));

    // R5
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vector_o == '0 && status_o == '0));

endmodule

// File: tb/tb_irq_accept_unit.sv
`timescale 1ns/1ps
module tb_irq_accept_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_level_i = '0;
    logic        int_req_i = 1'b0;
    logic [3:0]  int_level_i = '0;
    logic [6:0]  int_vector_i = '0;
    logic [31:0] status_i = '0;
    logic        boundary_i = 1'b0;
    logic        delay_slot_i = 1'b0;
    logic        take_o, ack_ext_o, ack_int_o, busy_o;
    logic [6:0]  vector_o;
    logic [31:0] status_o;

    always #2.5 clk = ~clk;

    irq_accept_unit dut (
        .clk(clk), .rst_n(rst_n),
        .ext_level_i(ext_level_i), .int_req_i(int_req_i),
        .int_level_i(int_level_i), .int_vector_i(int_vector_i),
        .status_i(status_i), .boundary_i(boundary_i), .delay_slot_i(delay_slot_i),
        .take_o(take_o), .vector_o(vector_o), .status_o(status_o),
        .ack_ext_o(ack_ext_o), .ack_int_o(ack_int_o), .busy_o(busy_o)
    );

    // Behavioural reference model
    int          m_ext = 0, m_intl = 0, m_intv = 0, m_phase = 0;
    int          e_take = 0, e_vec = 0, e_ackx = 0, e_acki = 0, e_busy = 0;
    logic [31:0] e_sr = '0;
    int          compared = 0, mismatched = 0, cycles = 0;
    string       tag = "R11";

    always @(posedge clk) begin
        int lvl, vec, src;
        bit acc;
        if (!rst_n) begin
            m_ext = 0; m_intl = 0; m_intv = 0; m_phase = 0;
            e_take = 0; e_vec = 0; e_ackx = 0; e_acki = 0; e_busy = 0; e_sr = '0;
        end else begin
            acc = 0; lvl = 0; vec = 0; src = 0;
            if (m_phase == 0 && boundary_i && !delay_slot_i) begin
                if (m_ext > m_intl) begin lvl = m_ext; vec = 64 + m_ext / 2; src = 1; end
                else begin lvl = m_intl; vec = m_intv; src = 2; end
                if (lvl > int'(status_i[7:4])) acc = 1;
            end
            e_take = acc;
            e_vec  = acc ? vec : 0;
            e_sr   = acc ? ((status_i & ~32'h0000_00F0) | (32'(lvl) << 4)) : 32'h0;
            e_ackx = (acc && src == 1);
            e_acki = (acc && src == 2);
            if (acc) m_phase = 1;
            else if (m_phase != 0) m_phase = (m_phase == 13) ? 0 : m_phase + 1;
            e_busy = (m_phase != 0);
            if (int_req_i) begin m_intl = int_level_i; m_intv = int_vector_i; end
            else if (acc && src == 2) begin m_intl = 0; m_intv = 0; end
            m_ext = ext_level_i;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        compared++;
        if (int'(take_o) != e_take || int'(vector_o) != e_vec || status_o != e_sr ||
            int'(ack_ext_o) != e_ackx || int'(ack_int_o) != e_acki || int'(busy_o) != e_busy) begin
            mismatched++;
            $display("FAIL %s t=%0t take=%0d/%0d vec=%0d/%0d sr=%h/%h ackx=%0d/%0d acki=%0d/%0d busy=%0d/%0d",
                     tag, $time, take_o, e_take, vector_o, e_vec, status_o, e_sr,
                     ack_ext_o, e_ackx, ack_int_o, e_acki, busy_o, e_busy);
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_int(int lvl, int vec);
        int_level_i = 4'(lvl); int_vector_i = 7'(vec); int_req_i = 1'b1;
        wait_cyc(1);
        int_req_i = 1'b0;
    endtask

    task automatic boundary_pulse(int n);
        boundary_i = 1'b1;
        wait_cyc(n);
        boundary_i = 1'b0;
    endtask

    initial begin
        // R11: reset state
        tag = "R11";
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10 / R4: internal request latched and taken with its vector
        tag = "R4";
        strobe_int(5, 7'h33);
        boundary_pulse(1);
        wait_cyc(16);

        // R7: delay slot blocks acceptance, plain boundary then accepts
        tag = "R7";
        strobe_int(6, 7'h10);
        delay_slot_i = 1'b1; boundary_pulse(5); delay_slot_i = 1'b0;
        wait_cyc(3);
        boundary_pulse(1);
        wait_cyc(16);

        // R1: tie goes to internal
        tag = "R1";
        ext_level_i = 4'd5;
        strobe_int(5, 7'h21);
        boundary_pulse(1);
        wait_cyc(16);
        // R6: external still pending, taken next (vector 66)
        tag = "R6";
        boundary_pulse(1);
        wait_cyc(16);
        ext_level_i = 4'd0;
        wait_cyc(2);

        // R1 / R3: strictly higher external wins (vector 68), then internal remains
        tag = "R3";
        ext_level_i = 4'd9;
        strobe_int(3, 7'h05);
        boundary_pulse(1);
        wait_cyc(16);
        ext_level_i = 4'd0;
        wait_cyc(2);
        tag = "R6";
        boundary_pulse(1);
        wait_cyc(16);

        // R2 / R5: masked at equal level, accepted one step below, other bits kept
        tag = "R2";
        status_i = 32'hA5A5_0F9F;
        ext_level_i = 4'd9;
        wait_cyc(2);
        boundary_pulse(3);
        tag = "R5";
        status_i = 32'hA5A5_0F8F;
        boundary_pulse(1);
        wait_cyc(16);
        ext_level_i = 4'd0;
        status_i = 32'h0;
        wait_cyc(2);
        // R2: level 0 internal is never taken
        tag = "R2";
        strobe_int(0, 7'h44);
        boundary_pulse(3);
        wait_cyc(2);

        // R8: boundary held, external level held; takes spaced by busy window
        tag = "R8";
        ext_level_i = 4'd15;
        wait_cyc(1);
        boundary_pulse(40);
        ext_level_i = 4'd0;
        wait_cyc(16);

        // R10: newer strobe replaces older request
        tag = "R10";
        strobe_int(4, 7'h11);
        strobe_int(7, 7'h22);
        boundary_pulse(1);
        wait_cyc(16);
        // R10: strobe in the accepting cycle stays pending
        strobe_int(3, 7'h01);
        int_level_i = 4'd2; int_vector_i = 7'h02; int_req_i = 1'b1; boundary_i = 1'b1;
        wait_cyc(1);
        int_req_i = 1'b0; boundary_i = 1'b0;
        wait_cyc(16);
        tag = "R9";
        boundary_pulse(1);
        wait_cyc(16);

        // R11: reset mid-entry returns to idle outputs
        tag = "R11";
        strobe_int(8, 7'h7F);
        boundary_pulse(1);
        wait_cyc(3);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        boundary_pulse(2);
        wait_cyc(4);

        finish_run();
    end

endmodule